// File: doc/BRIEF.md
# Six-Step Hall Commutation Decoder with Direction Control

This block turns the three digitised Hall-sensor bits of a three-phase brushless motor into gate enables for a six-transistor bipolar bridge. For every valid rotor position it turns on exactly one high-side (source) switch and one low-side (sink) switch on two different phases. A direction input reverses the rotation. In reverse, the Hall code is bit-inverted and then sent through the same position table.

Drive strength comes from chopping only the low-side switch with an externally generated PWM-on level. The high-side switch of the active step stays fully on. A peak-current trip cuts the low-side on-time short and keeps it off until the next PWM period begins. A stop request turns every switch off. A lock-protection shutdown forces the low side off. Whenever the target step or the direction changes, a dead-time counter holds all six switches off before the new pair is enabled. This prevents shoot-through.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir_rev_i`=0, Hall code {IN1,IN2,IN3} = `hall_i[2:0]` selects (source, sink) phases: 101→(2,1), 100→(3,1), 110→(3,2), 010→(1,2), 011→(1,3), 001→(2,3). Phase n is bit n-1 of `hs_en_o` / `ls_en_o`.
- R2: With `dir_rev_i`=1, the bitwise complement of `hall_i` is applied to the R1 table.
- R3: Codes 000 and 111 (after any complement) turn all six enables off.
- R4: When `{dir_rev_i, hall_i}` differs from its value on the previous clock, both enable vectors are 0 for DEAD_CYCLES+1 clocks. After reset the same hold applies. The new pair then appears if the inputs are still stable.
- R5: Each output is registered one clock after its inputs. `ls_en_o` is on only while `pwm_on_i`=1. `hs_en_o` does not depend on `pwm_on_i`.
- R6: `ilim_trip_i`=1 forces `ls_en_o` off. The trip stays latched until the next rising edge of `pwm_on_i`, which clears it unless `ilim_trip_i` is still high. `hs_en_o` is unaffected.
- R7: `run_i`=0 turns all six enables off.
- R8: `prot_off_i`=1 forces `ls_en_o` off while `hs_en_o` keeps its active phase.
- R9: While `rst_n`=0, all enables are 0.
- R10: No phase ever has both its high-side and low-side enable on. At most one bit of each vector is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall bits, [2]=sensor 1, [1]=sensor 2, [0]=sensor 3 |
| dir_rev_i | input | 1 | 0 forward, 1 reverse |
| run_i | input | 1 | 1 run, 0 stop |
| pwm_on_i | input | 1 | PWM on-phase level |
| ilim_trip_i | input | 1 | Peak-current limit trip |
| prot_off_i | input | 1 | Lock-protection shutdown |
| hs_en_o | output | 3 | High-side (source) enables, bit n-1 = phase n |
| ls_en_o | output | 3 | Low-side (sink) enables, bit n-1 = phase n |

## Verification
The bench sweeps every code in both directions. A swapped or mis-ordered table shows up as the wrong phase on one step. A reverse path that does not complement drives the motor the forward way. It changes the step mid-run and counts the off cycles exactly. A counter that is one short lets the old and new pairs overlap, and one that never reloads skips the blanking. A trip pulse is followed by a still-high PWM level: a trip that is not latched re-enables the sink within that period, and one that never clears leaves the sink dead in the next period. Stop and protection are also applied against an active step. Protection that gates the high side as well, or stop that leaves one side on, is reported at the ports.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;
   localparam int unsigned NPHASE = 3;
   typedef logic [NPHASE-1:0] phase_vec_t;
   typedef struct packed {
      phase_vec_t src;
      phase_vec_t snk;
   } drive_pair_t;
endpackage

// File: rtl/bldc_comm_decode.sv
module bldc_comm_decode
   import bldc_comm_pkg::*;
(
   input  logic [2:0]  hall_i,
   input  logic        rev_i,
   output drive_pair_t pair_o
);
   logic [2:0] code;

   // reverse rotation: same table, inverted sensor code
   assign code = rev_i ? ~hall_i : hall_i;

   always_comb begin
      unique case (code)
         3'b101:  pair_o = '{src: 3'b010, snk: 3'b001};
         3'b100:  pair_o = '{src: 3'b100, snk: 3'b001};
         3'b110:  pair_o = '{src: 3'b100, snk: 3'b010};
         3'b010:  pair_o = '{src: 3'b001, snk: 3'b010};
         3'b011:  pair_o = '{src: 3'b001, snk: 3'b100};
         3'b001:  pair_o = '{src: 3'b010, snk: 3'b100};
         default: pair_o = '{src: 3'b000, snk: 3'b000};
      endcase
   end
endmodule

// File: rtl/bldc_dead_gate.sv
module bldc_dead_gate #(
   parameter int unsigned DEAD_CYCLES = 4,
   parameter int unsigned KEY_W       = 4,
   localparam int unsigned CNT_W      = $clog2(DEAD_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key_i,
   output logic             open_o
);
   logic [KEY_W-1:0] key_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         cnt_q <= CNT_W'(DEAD_CYCLES);
      end else if (key_i != key_q) begin
         key_q <= key_i;
         cnt_q <= CNT_W'(DEAD_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign open_o = (key_i == key_q) && (cnt_q == '0);

   // R4: a freshly loaded key keeps the gate shut on the next cycle
   a_r4_reload_shut: assert property (@(posedge clk) disable iff (!rst_n)
      (key_i != key_q) |=> !open_o);
endmodule

// File: rtl/bldc_low_chop.sv
module bldc_low_chop (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_on_i,
   input  logic ilim_i,
   output logic allow_o
);
   logic pwm_q, trip_q, period_start;

   assign period_start = pwm_on_i && !pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q  <= 1'b0;
         trip_q <= 1'b0;
      end else begin
         pwm_q  <= pwm_on_i;
         trip_q <= period_start ? ilim_i : (trip_q | ilim_i);
      end
   end

   assign allow_o = pwm_on_i && !ilim_i && !(trip_q && !period_start);

   // R6: a latched trip holds the sink off until a new period starts
   a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ilim_i && pwm_on_i) |=> (!pwm_on_i || $past(pwm_on_i)) |-> !allow_o);
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_comm_pkg::*;
#(
   parameter int unsigned DEAD_CYCLES = 4,
   parameter bit          SYNC_HALL   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_i,
   input  logic       dir_rev_i,
   input  logic       run_i,
   input  logic       pwm_on_i,
   input  logic       ilim_trip_i,
   input  logic       prot_off_i,
   output logic [2:0] hs_en_o,
   output logic [2:0] ls_en_o
);
   localparam int unsigned KEY_W = 4;

   if (DEAD_CYCLES < 1) begin : g_bad_dead
      initial $fatal(1, "DEAD_CYCLES must be at least 1");
   end
   if (NPHASE != 3) begin : g_bad_phase
      initial $fatal(1, "six-step table needs three phases");
   end

   logic [2:0]  hall_s;
   logic        dir_s;
   drive_pair_t pair;
   logic        dt_open, chop_allow;
   phase_vec_t  hs_q, ls_q;

   if (SYNC_HALL) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hall_s <= '0;
            dir_s  <= 1'b0;
         end else begin
            hall_s <= hall_i;
            dir_s  <= dir_rev_i;
         end
      end
   end else begin : g_direct
      assign hall_s = hall_i;
      assign dir_s  = dir_rev_i;
   end

   bldc_comm_decode u_dec (
      .hall_i (hall_s),
      .rev_i  (dir_s),
      .pair_o (pair)
   );

   bldc_dead_gate #(.DEAD_CYCLES(DEAD_CYCLES), .KEY_W(KEY_W)) u_dead (
      .clk    (clk),
      .rst_n  (rst_n),
      .key_i  ({dir_s, hall_s}),
      .open_o (dt_open)
   );

   bldc_low_chop u_chop (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_on_i (pwm_on_i),
      .ilim_i   (ilim_trip_i),
      .allow_o  (chop_allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= '0;
         ls_q <= '0;
      end else begin
         hs_q <= (run_i && dt_open) ? pair.src : '0;
         ls_q <= (run_i && dt_open && !prot_off_i && chop_allow) ? pair.snk : '0;
      end
   end

   assign hs_en_o = hs_q;
   assign ls_en_o = ls_q;

   a_r7_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (hs_en_o == '0 && ls_en_o == '0));
   a_r8_prot_low_off: assert property (@(posedge clk) disable iff (!rst_n)
      prot_off_i |=> (ls_en_o == '0));
   a_r5_pwm_low_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_on_i |=> (ls_en_o == '0));
   a_r6_trip_low_off: assert property (@(posedge clk) disable iff (!rst_n)
      ilim_trip_i |=> (ls_en_o == '0));
   a_r3_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
      (hall_s == 3'b000 || hall_s == 3'b111) |=> (hs_en_o == '0 && ls_en_o == '0));
   a_r4_dead_off: assert property (@(posedge clk) disable iff (!rst_n)
      !dt_open |=> (hs_en_o == '0 && ls_en_o == '0));
   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hs_en_o) && $onehot0(ls_en_o));
   for (genvar p = 0; p < NPHASE; p++) begin : g_leg
      a_r10_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
         !(hs_en_o[p] && ls_en_o[p]));
   end
endmodule

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;
   localparam int DT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_i = '0;
   logic       dir_rev_i = 1'b0, run_i = 1'b0, pwm_on_i = 1'b0;
   logic       ilim_trip_i = 1'b0, prot_off_i = 1'b0;
   logic [2:0] hs_en_o, ls_en_o;

   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state, kept from the requirements
   logic [3:0] m_key;
   int         m_cnt;
   logic       m_trip, m_pwm_prev;

   always #2 clk = ~clk;

   bldc_commutator #(.DEAD_CYCLES(DT)) uut (
      .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .dir_rev_i(dir_rev_i),
      .run_i(run_i), .pwm_on_i(pwm_on_i), .ilim_trip_i(ilim_trip_i),
      .prot_off_i(prot_off_i), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o));

   // R1 table: returns {src, snk}, bit n-1 = phase n
   function automatic logic [5:0] table_pair(input logic [2:0] c);
      case (c)
         3'b101: return {3'b010, 3'b001};
         3'b100: return {3'b100, 3'b001};
         3'b110: return {3'b100, 3'b010};
         3'b010: return {3'b001, 3'b010};
         3'b011: return {3'b001, 3'b100};
         3'b001: return {3'b010, 3'b100};
         default: return 6'b0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [2:0] act, exp_v, input string what);
      n_vec++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b", tag, what, act, exp_v);
      end
   endtask

   task automatic step(input logic [2:0] h, input logic d, r, p, t, pr, input string tag);
      logic [3:0] key;
      logic [5:0] pr_v;
      logic       open, rise, tnow;
      logic [2:0] eh, el;
      hall_i = h; dir_rev_i = d; run_i = r; pwm_on_i = p; ilim_trip_i = t; prot_off_i = pr;
      key  = {d, h};
      pr_v = table_pair(d ? ~h : h);
      open = (key == m_key) && (m_cnt == 0);
      rise = p && !m_pwm_prev;
      tnow = t || (m_trip && !rise);
      eh = (r && open) ? pr_v[5:3] : 3'b000;
      el = (r && open && !pr && p && !tnow) ? pr_v[2:0] : 3'b000;
      if (key != m_key) begin m_key = key; m_cnt = DT; end
      else if (m_cnt > 0) m_cnt--;
      m_trip = rise ? t : (m_trip || t);
      m_pwm_prev = p;
      @(posedge clk);
      @(negedge clk);
      check(tag, hs_en_o, eh, "high-side");
      check(tag, ls_en_o, el, "low-side");
      n_vec++;
      if ((hs_en_o & ls_en_o) != 3'b000) begin
         n_bad++;
         $display("FAIL R10 shoot-through: hs %b ls %b expected no overlap", hs_en_o, ls_en_o);
      end
   endtask

   task automatic hold(input logic [2:0] h, input logic d, input int n, input string tag);
      for (int i = 0; i < n; i++) step(h, d, 1, 1, 0, 0, tag);
   endtask

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [2:0] fwd [6];
      fwd = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
      void'($urandom(32'd20240611));
      m_key = 4'b0; m_cnt = DT; m_trip = 1'b0; m_pwm_prev = 1'b0;
      repeat (3) @(negedge clk);
      check("R9", hs_en_o, 3'b000, "reset high-side");
      check("R9", ls_en_o, 3'b000, "reset low-side");
      rst_n = 1'b1;

      // R4 after reset, then R1 forward sweep
      hold(3'b101, 0, DT + 1, "R4");
      for (int i = 0; i < 6; i++) begin
         hold(fwd[i], 0, DT + 1, "R4");
         hold(fwd[i], 0, 2, "R1");
      end
      // R2 reverse sweep
      for (int i = 0; i < 6; i++) begin
         hold(fwd[i], 1, DT + 1, "R4");
         hold(fwd[i], 1, 2, "R2");
      end
      // R3 invalid codes both ways
      hold(3'b000, 0, DT + 3, "R3");
      hold(3'b111, 0, DT + 3, "R3");
      hold(3'b000, 1, DT + 3, "R3");
      hold(3'b111, 1, DT + 3, "R3");
      // R7 stop against an active step
      hold(3'b110, 0, DT + 3, "R4");
      for (int i = 0; i < 3; i++) step(3'b110, 0, 0, 1, 0, 0, "R7");
      hold(3'b110, 0, 2, "R7");
      // R8 protection keeps high side
      for (int i = 0; i < 3; i++) step(3'b110, 0, 1, 1, 0, 1, "R8");
      // R5 pwm chops only the low side
      for (int i = 0; i < 8; i++) step(3'b110, 0, 1, i[0], 0, 0, "R5");
      // R6 trip latched through the rest of the period
      step(3'b110, 0, 1, 1, 0, 0, "R6");
      step(3'b110, 0, 1, 1, 1, 0, "R6");
      for (int i = 0; i < 3; i++) step(3'b110, 0, 1, 1, 0, 0, "R6");
      step(3'b110, 0, 1, 0, 0, 0, "R6");
      for (int i = 0; i < 2; i++) step(3'b110, 0, 1, 1, 0, 0, "R6");
      // trip held across a period start keeps the sink off
      step(3'b110, 0, 1, 0, 1, 0, "R6");
      step(3'b110, 0, 1, 1, 1, 0, "R6");
      step(3'b110, 0, 1, 1, 0, 0, "R6");

      // random mix
      for (int blk = 0; blk < 600; blk++) begin
         logic [2:0] h;
         logic d;
         int len;
         h = 3'($urandom_range(0, 7));
         d = 1'($urandom_range(0, 1));
         len = $urandom_range(1, 2 * DT + 4);
         for (int i = 0; i < len; i++)
            step(h, d, ($urandom_range(0, 19) != 0), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 14) == 0), "R10");
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule